// File: doc/BRIEF.md
# Page Write Collector and Commit Sequencer

This block sits behind a two-wire serial slave and handles the write side of a small 128 x 8 non-volatile array. The slave hands it a word address, then a run of data bytes, then a stop event. The bytes are held in an eight-slot page buffer. On stop, the buffered bytes are committed to the array through a simple write port, and a busy flag is held for a fixed self-timed write period. While busy, the slave withholds its acknowledge, so the host can poll for completion by sending a write control byte repeatedly.

The pointer steps through its low three bits only. A burst that starts mid-page therefore folds back to the start of the same page. A burst longer than eight bytes overwrites slots that were filled earlier in the same transaction. A write-enable level, shared with the stream clock pin, is sampled at the moment of stop. If it is low, the collected bytes are dropped and no write period starts. Changes of that level after the write period has begun have no effect. The length of the write period is a parameter counted in system clock cycles, and it must be larger than the page size.

Top module: `pagewr_seq`

## Requirements
- R1: After reset, `busy` and `arrWe` are low and `ptr` is 0.
- R2: When idle, a pulse on `addrLoad` sets `ptr` to `addrIn` on the next clock edge.
- R3: When idle, each `byteWr` pulse stores `byteIn` in the slot named by `ptr[2:0]`. It then advances only `ptr[2:0]`, modulo 8, while `ptr[6:3]` (the page) stays fixed, so a burst never reaches the next page.
- R4: When more than eight bytes arrive before stop, each slot holds the last byte written to it, and that value is what gets committed.
- R5: A stop with `wpLevel` high and at least one byte buffered raises `busy` at the next edge. `busy` then stays high for exactly `WR_CYCLES` clock cycles.
- R6: During commit, each filled slot is written once to the array at address `{page, slot}`. Slots go in ascending order, at most one per cycle, and only while `busy` is high. Locations whose slots were not filled are not written.
- R7: A stop with `wpLevel` low writes nothing, leaves `busy` low and discards the buffer, so a later stop with `wpLevel` high also writes nothing.
- R8: Dropping `wpLevel` after the commit has started does not change which bytes are written.
- R9: While `busy` is high, `addrLoad`, `byteWr` and `stopEvt` are ignored: `ptr` does not change and no further bytes are buffered or written.
- R10: A stop with no bytes buffered (address only) leaves `busy` low and writes nothing.
- R11: A new `addrLoad` drops any bytes buffered since the previous load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrLoad | input | 1 | One-cycle strobe: load the word address |
| addrIn | input | 7 | Word address presented with `addrLoad` |
| byteWr | input | 1 | One-cycle strobe: a data byte was received |
| byteIn | input | 8 | Data byte presented with `byteWr` |
| stopEvt | input | 1 | One-cycle strobe: stop condition seen |
| wpLevel | input | 1 | Write-enable level; high permits programming |
| busy | output | 1 | Self-timed write period in progress |
| ptr | output | 7 | Current address pointer |
| arrWe | output | 1 | Array write enable, one cycle per byte |
| arrAddr | output | 7 | Array write address |
| arrData | output | 8 | Array write data |

## Verification
The assertions assume that the slave raises at most one of `addrLoad`, `byteWr` and `stopEvt` in any cycle, and that each strobe lasts a single cycle. The directed tasks drive every strobe as a lone one-cycle pulse on the falling clock edge to satisfy this. The assertions also assume that `WR_CYCLES` exceeds the page size. The bench sets it to 40.

// File: rtl/pagewr_pkg.sv
package pagewr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_HOLD = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadPtr;    // take a new word address, drop buffer
    logic storeByte;  // capture byte into current slot
    logic arm;        // start commit scan
    logic drop;       // discard buffer without writing
    logic scanEn;     // scan phase: present one slot per cycle
    logic finish;     // write period over, clear buffer
  } ctlStrobe_t;

endpackage

// File: rtl/pagewr_ctrl.sv
module pagewr_ctrl
  import pagewr_pkg::*;
#(
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 2000000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       addrLoad,
  input  logic       byteWr,
  input  logic       stopEvt,
  input  logic       wpLevel,
  input  logic       anyValid,
  output ctlStrobe_t ctl,
  output logic       busy
);

  localparam int TMR_W = $clog2(WR_CYCLES + 1);
  localparam logic [TMR_W-1:0] SCAN_END = TMR_W'(PAGE_BYTES - 1);
  localparam logic [TMR_W-1:0] LAST_T   = TMR_W'(WR_CYCLES - 1);

  seqState_t state, nextState;
  logic [TMR_W-1:0] timer;

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (stopEvt) begin
          if (wpLevel && anyValid) begin
            ctl.arm   = 1'b1;
            nextState = ST_SCAN;
          end else begin
            ctl.drop = 1'b1;
          end
        end else if (addrLoad) begin
          ctl.loadPtr = 1'b1;
        end else if (byteWr) begin
          ctl.storeByte = 1'b1;
        end
      end
      ST_SCAN: begin
        ctl.scanEn = 1'b1;
        if (timer == SCAN_END) nextState = ST_HOLD;
      end
      ST_HOLD: begin
        if (timer == LAST_T) begin
          ctl.finish = 1'b1;
          nextState  = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      timer <= '0;
    end else begin
      state <= nextState;
      if (ctl.arm)               timer <= '0;
      else if (state != ST_IDLE) timer <= timer + TMR_W'(1);
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/pagewr_dpath.sv
module pagewr_dpath
  import pagewr_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        ctl,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] byteIn,
  output logic              anyValid,
  output logic [ADDR_W-1:0] ptr,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData
);

  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - SLOT_W;

  logic [PAGE_W-1:0]     pageSel;
  logic [SLOT_W-1:0]     slotSel;
  logic [SLOT_W-1:0]     scanIdx;
  logic [PAGE_BYTES-1:0] validMask;
  logic [DATA_W-1:0]     slotData [PAGE_BYTES];

  assign pageSel = ptr[ADDR_W-1:SLOT_W];
  assign slotSel = ptr[SLOT_W-1:0];

  // Pointer: full load, or low-bit step inside the page
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (ctl.loadPtr) begin
      ptr <= addrIn;
    end else if (ctl.storeByte) begin
      ptr <= {pageSel, slotSel + SLOT_W'(1)};
    end
  end

  // Slot storage, one register per slot
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (ctl.storeByte && (slotSel == SLOT_W'(g)))
        slotData[g] <= byteIn;
    end

    always_ff @(posedge clk) begin
      if (!rstN)
        validMask[g] <= 1'b0;
      else if (ctl.loadPtr || ctl.drop || ctl.finish)
        validMask[g] <= 1'b0;
      else if (ctl.storeByte && (slotSel == SLOT_W'(g)))
        validMask[g] <= 1'b1;
    end
  end

  // Commit scan index
  always_ff @(posedge clk) begin
    if (!rstN)           scanIdx <= '0;
    else if (ctl.arm)    scanIdx <= '0;
    else if (ctl.scanEn) scanIdx <= scanIdx + SLOT_W'(1);
  end

  assign anyValid = |validMask;
  assign arrWe    = ctl.scanEn && validMask[scanIdx];
  assign arrAddr  = {pageSel, scanIdx};
  assign arrData  = slotData[scanIdx];

endmodule

// File: rtl/pagewr_seq.sv
module pagewr_seq
  import pagewr_pkg::*;
#(
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 2000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              byteWr,
  input  logic [DATA_W-1:0] byteIn,
  input  logic              stopEvt,
  input  logic              wpLevel,
  output logic              busy,
  output logic [ADDR_W-1:0] ptr,
  output logic              arrWe,
  output logic [ADDR_W-1:0] arrAddr,
  output logic [DATA_W-1:0] arrData
);

  ctlStrobe_t ctl;
  logic       anyValid;

  pagewr_ctrl #(
    .PAGE_BYTES(PAGE_BYTES),
    .WR_CYCLES (WR_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .addrLoad(addrLoad),
    .byteWr  (byteWr),
    .stopEvt (stopEvt),
    .wpLevel (wpLevel),
    .anyValid(anyValid),
    .ctl     (ctl),
    .busy    (busy)
  );

  pagewr_dpath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .addrIn  (addrIn),
    .byteIn  (byteIn),
    .anyValid(anyValid),
    .ptr     (ptr),
    .arrWe   (arrWe),
    .arrAddr (arrAddr),
    .arrData (arrData)
  );

endmodule

// File: rtl/pagewr_chk.sv
module pagewr_chk #(
  parameter int ADDR_W     = 7,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 2000000
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrLoad,
  input logic              byteWr,
  input logic              stopEvt,
  input logic              wpLevel,
  input logic              busy,
  input logic [ADDR_W-1:0] ptr,
  input logic              arrWe,
  input logic [ADDR_W-1:0] arrAddr
);

  localparam int SLOT_W = $clog2(PAGE_BYTES);
  localparam int RUN_W  = $clog2(WR_CYCLES + 1) + 1;

  logic [RUN_W-1:0] busyRun;

  always_ff @(posedge clk) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + RUN_W'(1);
    else           busyRun <= '0;
  end

  assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rstN)
    (byteWr && !busy && !stopEvt && !addrLoad) |=>
      (ptr[ADDR_W-1:SLOT_W] == $past(ptr[ADDR_W-1:SLOT_W])));

  assert_busy_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(stopEvt) && $past(wpLevel)));

  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyRun < RUN_W'(WR_CYCLES)));

  assert_busy_exact_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(busyRun) == RUN_W'(WR_CYCLES - 1)));

  assert_we_in_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> busy);

  assert_we_page_R6: assert property (@(posedge clk) disable iff (!rstN)
    arrWe |-> (arrAddr[ADDR_W-1:SLOT_W] == ptr[ADDR_W-1:SLOT_W]));

  assert_wp_block_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stopEvt && !wpLevel && !busy) |=> !busy);

  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(ptr));

endmodule

bind pagewr_seq pagewr_chk #(
  .ADDR_W    (ADDR_W),
  .PAGE_BYTES(PAGE_BYTES),
  .WR_CYCLES (WR_CYCLES)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .addrLoad(addrLoad),
  .byteWr  (byteWr),
  .stopEvt (stopEvt),
  .wpLevel (wpLevel),
  .busy    (busy),
  .ptr     (ptr),
  .arrWe   (arrWe),
  .arrAddr (arrAddr)
);

// File: tb/sim_pagewr_seq.sv
`timescale 1ns/1ps
module sim_pagewr_seq;

  localparam int WCYC = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       addrLoad = 1'b0;
  logic [6:0] addrIn = '0;
  logic       byteWr = 1'b0;
  logic [7:0] byteIn = '0;
  logic       stopEvt = 1'b0;
  logic       wpLevel = 1'b1;
  logic       busy;
  logic [6:0] ptr;
  logic       arrWe;
  logic [6:0] arrAddr;
  logic [7:0] arrData;

  int checks = 0;
  int failures = 0;
  int wrCount = 0;
  logic [7:0] mirror [128];
  logic [7:0] expMem [128];

  always #2.5 clk = ~clk;

  pagewr_seq #(.WR_CYCLES(WCYC)) u0 (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .addrIn(addrIn),
    .byteWr(byteWr), .byteIn(byteIn), .stopEvt(stopEvt), .wpLevel(wpLevel),
    .busy(busy), .ptr(ptr), .arrWe(arrWe), .arrAddr(arrAddr), .arrData(arrData)
  );

  // Array model fed by the write port
  always @(negedge clk) begin
    if (arrWe) begin
      mirror[arrAddr] = arrData;
      wrCount++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  task automatic doLoad(input logic [6:0] a);
    @(negedge clk); addrLoad = 1'b1; addrIn = a;
    @(negedge clk); addrLoad = 1'b0;
  endtask

  task automatic doByte(input logic [7:0] d);
    @(negedge clk); byteWr = 1'b1; byteIn = d;
    @(negedge clk); byteWr = 1'b0;
  endtask

  task automatic doStop(input logic wp);
    @(negedge clk); stopEvt = 1'b1; wpLevel = wp;
    @(negedge clk); stopEvt = 1'b0;
  endtask

  // Counts busy cycles from the negedge after stop
  task automatic waitIdle(output int n);
    n = 0;
    while (busy && n < 10 * WCYC) begin
      n++;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic cmpArray(input string req);
    int bad = -1;
    for (int i = 0; i < 128; i++)
      if (mirror[i] !== expMem[i] && bad < 0) bad = i;
    if (bad < 0) chk(1'b1, req, "array", 0, 0);
    else chk(1'b0, req, $sformatf("array[0x%0h]", bad), int'(mirror[bad]), int'(expMem[bad]));
  endtask

  task automatic tReset();
    chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
    chk(arrWe == 1'b0, "R1", "arrWe", int'(arrWe), 0);
    chk(ptr == 7'd0, "R1", "ptr", int'(ptr), 0);
  endtask

  task automatic tLoad();
    doLoad(7'h35);
    chk(ptr == 7'h35, "R2", "ptr after load", int'(ptr), 'h35);
    doLoad(7'h00);
  endtask

  task automatic tSingle();
    int n; int w0 = wrCount;
    doLoad(7'h10);
    doByte(8'hA5);
    chk(ptr == 7'h11, "R3", "ptr step", int'(ptr), 'h11);
    doStop(1'b1);
    chk(busy == 1'b1, "R5", "busy after stop", int'(busy), 1);
    waitIdle(n);
    chk(n == WCYC, "R5", "busy length", n, WCYC);
    expMem['h10] = 8'hA5;
    chk(wrCount - w0 == 1, "R6", "write count", wrCount - w0, 1);
    cmpArray("R6");
  endtask

  task automatic tWrap();
    int n; int w0 = wrCount;
    doLoad(7'h1D);
    doByte(8'h11); doByte(8'h22); doByte(8'h33); doByte(8'h44);
    chk(ptr == 7'h19, "R3", "ptr wrap in page", int'(ptr), 'h19);
    doStop(1'b1);
    waitIdle(n);
    expMem['h1D] = 8'h11; expMem['h1E] = 8'h22;
    expMem['h1F] = 8'h33; expMem['h18] = 8'h44;
    chk(wrCount - w0 == 4, "R6", "wrap write count", wrCount - w0, 4);
    chk(mirror['h20] == 8'h00, "R3", "next page untouched", int'(mirror['h20]), 0);
    cmpArray("R3");
  endtask

  task automatic tOverflow();
    int n; int w0 = wrCount;
    doLoad(7'h40);
    for (int i = 0; i < 10; i++) doByte(8'hB0 + 8'(i));
    doStop(1'b1);
    waitIdle(n);
    for (int i = 0; i < 8; i++) expMem['h40 + i] = 8'hB0 + 8'(i);
    expMem['h40] = 8'hB8; expMem['h41] = 8'hB9;
    chk(wrCount - w0 == 8, "R4", "overflow write count", wrCount - w0, 8);
    chk(mirror['h40] == 8'hB8, "R4", "slot0 overwritten", int'(mirror['h40]), 'hB8);
    cmpArray("R4");
  endtask

  task automatic tWpLow();
    int w0 = wrCount;
    doLoad(7'h50);
    doByte(8'hC1); doByte(8'hC2);
    doStop(1'b0);
    chk(busy == 1'b0, "R7", "busy with wp low", int'(busy), 0);
    repeat (WCYC) @(negedge clk);
    chk(wrCount == w0, "R7", "no write wp low", wrCount - w0, 0);
    doStop(1'b1);
    chk(busy == 1'b0, "R7", "busy after discard", int'(busy), 0);
    repeat (12) @(negedge clk);
    chk(wrCount == w0, "R7", "buffer discarded", wrCount - w0, 0);
    cmpArray("R7");
  endtask

  task automatic tWpDrop();
    int n; int w0 = wrCount;
    doLoad(7'h60);
    doByte(8'hD0); doByte(8'hD1); doByte(8'hD2);
    doStop(1'b1);
    wpLevel = 1'b0;
    waitIdle(n);
    wpLevel = 1'b1;
    expMem['h60] = 8'hD0; expMem['h61] = 8'hD1; expMem['h62] = 8'hD2;
    chk(wrCount - w0 == 3, "R8", "writes after wp drop", wrCount - w0, 3);
    cmpArray("R8");
  endtask

  task automatic tBusyIgnore();
    int n; int w0 = wrCount;
    doLoad(7'h70);
    doByte(8'hE1);
    doStop(1'b1);
    doLoad(7'h00);
    doByte(8'hEE);
    doStop(1'b1);
    chk(ptr == 7'h71, "R9", "ptr during busy", int'(ptr), 'h71);
    waitIdle(n);
    chk(ptr == 7'h71, "R9", "ptr after busy", int'(ptr), 'h71);
    doStop(1'b1);
    chk(busy == 1'b0, "R9", "no byte kept from busy", int'(busy), 0);
    repeat (12) @(negedge clk);
    expMem['h70] = 8'hE1;
    chk(wrCount - w0 == 1, "R9", "write count", wrCount - w0, 1);
    cmpArray("R9");
  endtask

  task automatic tEmptyStop();
    int w0 = wrCount;
    doLoad(7'h22);
    doStop(1'b1);
    chk(busy == 1'b0, "R10", "busy on empty stop", int'(busy), 0);
    repeat (12) @(negedge clk);
    chk(wrCount == w0, "R10", "no write", wrCount - w0, 0);
  endtask

  task automatic tReload();
    int w0 = wrCount;
    doLoad(7'h30);
    doByte(8'h77);
    doLoad(7'h31);
    doStop(1'b1);
    chk(busy == 1'b0, "R11", "busy after reload", int'(busy), 0);
    repeat (12) @(negedge clk);
    chk(wrCount == w0, "R11", "reload dropped bytes", wrCount - w0, 0);
    cmpArray("R11");
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      mirror[i] = 8'h00;
      expMem[i] = 8'h00;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tLoad();
    tSingle();
    tWrap();
    tOverflow();
    tWpLow();
    tWpDrop();
    tBusyIgnore();
    tEmptyStop();
    tReload();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule